// File: doc/BRIEF.md
# UART Bit Timing and Sample Strobe Generator

This block produces the per-bit timing of a high-speed serial port from one fixed input clock. A 16-bit divisor first slows the clock into ticks; a speed mode then decides how many ticks make one serial bit. That is 16 ticks or 4 ticks in the fixed modes, or a count taken straight from a register in the programmable mode. The transmit side gets a single-cycle strobe at every bit boundary. The receive side gets a single-cycle strobe at a chosen tick inside each bit.

The receive timing realigns itself to the falling edge that starts a character. After such an edge the receive counters restart, so the first strobe lands on the start bit at the programmed sample point. Further falling edges are ignored until a whole character of samples has been taken. Configuration is written over a byte-wide, word-indexed write port. Only the timing registers are stored. Writes that address the data or interrupt-enable words are accepted and have no effect here.

Top module: `uart_bit_timer`

## Requirements
- R1: While reset is asserted both strobes are low. After reset (divisor 0, speed mode 0, sample count 0, sample point 0xFF) the first transmit strobe follows 16 cycles after the reset release.
- R2: Speed mode 0 and speed mode 1 both give 16 ticks per bit, so the transmit strobe period is 16 × divisor cycles.
- R3: Speed mode 2 gives 4 ticks per bit, so the transmit strobe period is 4 × divisor cycles.
- R4: Speed mode 3 gives (sample count + 1) ticks per bit. The transmit period is then divisor × (sample count + 1) cycles, and this includes a sample count of 0 (one tick per bit).
- R5: A divisor of 0 behaves as a divisor of 1.
- R6: Word 0 loads the divisor low byte and word 1 loads the high byte, but only while bit 7 of the line-control byte (word 3) is set. With that bit clear, writes to words 0 and 1 leave the timing unchanged. Word 9 bits [1:0] hold the speed mode, word 10 the sample count and word 11 the sample point.
- R7: When the sample point S is below the ticks per bit and is not 0xFF, the receive strobe falls at tick S of each bit. After a start edge the first strobe appears 3 + (S + 1) × divisor cycles after the first clock edge that sees the line low: two of these cycles are synchronizer stages.
- R8: When the sample point is 0xFF, or is not below the ticks per bit, the receive strobe falls at tick max(ticks/2 − 1, 0).
- R9: A 1-to-0 transition on the receive line restarts the receive counters only when no character is in progress. A character is in progress from a restart until 10 receive strobes have been issued, and falling edges within it are ignored.
- R10: A write that changes the divisor, the speed mode or the sample count restarts both counters on that clock edge. The next transmit strobe then follows ticks × divisor cycles later, and the next receive strobe follows (sample tick + 1) × divisor cycles later. The write also ends any character in progress.
- R11: Each strobe is one cycle wide whenever a bit lasts more than one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register word index |
| wr_data_i | input | 8 | Register write data |
| rx_i | input | 1 | Serial receive line, idles high |
| tx_tick_o | output | 1 | Transmit bit-boundary strobe |
| rx_sample_o | output | 1 | Receive sample strobe |

## Verification
A wrong tick counter or a wrong ticks-per-bit choice shows up as a wrong strobe period on the very next bit, within one bit time of the faulty configuration. A wrong realignment shows up as a first receive strobe that is too early or too late after a start edge. A wrong in-progress flag shows up as a strobe that moves when a falling edge arrives in the middle of a character, and this is visible at the next sample. A missed restart on a configuration write shows up as a strobe that does not follow the write by exactly one bit time.

// File: rtl/uart_bt_pkg.sv
package uart_bt_pkg;
  localparam int DIV_W  = 16;
  localparam int BYTE_W = 8;
  localparam int SC_W   = 8;
  localparam int PH_W   = SC_W + 1;
  localparam int ADDR_W = 4;
  localparam int DLAB_BIT = 7;

  localparam logic [ADDR_W-1:0] REG_DIV_LO = 4'd0;
  localparam logic [ADDR_W-1:0] REG_DIV_HI = 4'd1;
  localparam logic [ADDR_W-1:0] REG_LINE   = 4'd3;
  localparam logic [ADDR_W-1:0] REG_SPEED  = 4'd9;
  localparam logic [ADDR_W-1:0] REG_SCNT   = 4'd10;
  localparam logic [ADDR_W-1:0] REG_SPT    = 4'd11;

  localparam logic [SC_W-1:0] SPT_AUTO = '1;

  typedef enum logic [1:0] {
    SPD_X16  = 2'd0,
    SPD_X16B = 2'd1,
    SPD_X4   = 2'd2,
    SPD_PROG = 2'd3
  } speed_e;

  function automatic logic [PH_W-1:0] bit_ticks(speed_e m, logic [SC_W-1:0] sc);
    case (m)
      SPD_X4:   bit_ticks = PH_W'(4);
      SPD_PROG: bit_ticks = {1'b0, sc} + PH_W'(1);
      default:  bit_ticks = PH_W'(16);
    endcase
  endfunction

  function automatic logic [PH_W-1:0] mid_tick(logic [PH_W-1:0] t);
    logic [PH_W-1:0] h;
    h = t >> 1;
    mid_tick = (h == '0) ? '0 : h - PH_W'(1);
  endfunction
endpackage

// File: rtl/uart_bt_regs.sv
module uart_bt_regs
  import uart_bt_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    wr_addr_i,
  input  logic [BYTE_W-1:0]    wr_data_i,
  output logic [DIV_W-1:0]     div_o,
  output speed_e               speed_o,
  output logic [SC_W-1:0]      scnt_o,
  output logic [SC_W-1:0]      spt_o,
  output logic                 cfg_restart_o
);
  localparam int HALF = DIV_W / 2;

  logic dlab_q;
  logic hit_lo, hit_hi, hit_line, hit_spd, hit_sc, hit_spt;

  assign hit_lo   = wr_en_i & dlab_q & (wr_addr_i == REG_DIV_LO);
  assign hit_hi   = wr_en_i & dlab_q & (wr_addr_i == REG_DIV_HI);
  assign hit_line = wr_en_i & (wr_addr_i == REG_LINE);
  assign hit_spd  = wr_en_i & (wr_addr_i == REG_SPEED);
  assign hit_sc   = wr_en_i & (wr_addr_i == REG_SCNT);
  assign hit_spt  = wr_en_i & (wr_addr_i == REG_SPT);

  // only value changes disturb the running counters
  assign cfg_restart_o = (hit_lo  && wr_data_i != div_o[HALF-1:0])
                       | (hit_hi  && wr_data_i != div_o[DIV_W-1:HALF])
                       | (hit_spd && speed_e'(wr_data_i[1:0]) != speed_o)
                       | (hit_sc  && wr_data_i != scnt_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dlab_q  <= 1'b0;
      div_o   <= '0;
      speed_o <= SPD_X16;
      scnt_o  <= '0;
      spt_o   <= SPT_AUTO;
    end else begin
      if (hit_line) dlab_q <= wr_data_i[DLAB_BIT];
      if (hit_lo)   div_o[HALF-1:0] <= wr_data_i;
      if (hit_hi)   div_o[DIV_W-1:HALF] <= wr_data_i;
      if (hit_spd)  speed_o <= speed_e'(wr_data_i[1:0]);
      if (hit_sc)   scnt_o <= wr_data_i;
      if (hit_spt)  spt_o <= wr_data_i;
    end
  end
endmodule

// File: rtl/uart_bt_lane.sv
module uart_bt_lane #(
  parameter int DIV_W = 16,
  parameter int PH_W  = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] div_eff_i,
  input  logic [PH_W-1:0]  tpb_i,
  input  logic [PH_W-1:0]  target_i,
  output logic             strobe_o,
  output logic [PH_W-1:0]  phase_o
);
  localparam logic [DIV_W-1:0] ONE_D = DIV_W'(1);
  localparam logic [PH_W-1:0]  ONE_P = PH_W'(1);

  logic [DIV_W-1:0] pcnt_q;
  logic             tick, last;

  assign tick    = (pcnt_q == div_eff_i - ONE_D);
  assign last    = (phase_o == tpb_i - ONE_P);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcnt_q   <= '0;
      phase_o  <= '0;
      strobe_o <= 1'b0;
    end else if (restart_i) begin
      pcnt_q   <= '0;
      phase_o  <= '0;
      strobe_o <= 1'b0;
    end else begin
      pcnt_q   <= tick ? '0 : pcnt_q + ONE_D;
      if (tick) phase_o <= last ? '0 : phase_o + ONE_P;
      strobe_o <= tick && (phase_o == target_i);
    end
  end
endmodule

// File: rtl/uart_bt_rxalign.sv
module uart_bt_rxalign #(
  parameter int FRAME_BITS  = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  input  logic cfg_restart_i,
  input  logic sample_i,
  output logic realign_o
);
  localparam int CNT_W = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(FRAME_BITS - 1);

  logic [SYNC_STAGES:0] sync_q;
  logic                 busy_q;
  logic [CNT_W-1:0]     cnt_q;
  logic                 fall;

  assign fall      = sync_q[SYNC_STAGES] & ~sync_q[SYNC_STAGES-1];
  assign realign_o = fall & ~busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-1:0], rx_i};
      if (cfg_restart_i) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else if (realign_o) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q && sample_i) begin
        if (cnt_q == LAST_CNT) busy_q <= 1'b0;
        else cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/uart_bit_timer.sv
module uart_bit_timer
  import uart_bt_pkg::*;
#(
  parameter int FRAME_BITS  = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              rx_i,
  output logic              tx_tick_o,
  output logic              rx_sample_o
);
  localparam int LANES = 2;

  logic [DIV_W-1:0] div_raw, div_eff;
  speed_e           speed;
  logic [SC_W-1:0]  scnt, spt;
  logic             cfg_restart, rx_realign;
  logic [PH_W-1:0]  tpb, mid, sample_idx;
  logic [PH_W-1:0]  tx_phase, rx_phase;

  logic [LANES-1:0]           lane_restart, lane_strobe;
  logic [LANES-1:0][PH_W-1:0] lane_target, lane_phase;

  uart_bt_regs u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .div_o(div_raw), .speed_o(speed), .scnt_o(scnt), .spt_o(spt),
    .cfg_restart_o(cfg_restart)
  );

  assign div_eff    = (div_raw == '0) ? DIV_W'(1) : div_raw;
  assign tpb        = bit_ticks(speed, scnt);
  assign mid        = mid_tick(tpb);
  assign sample_idx = (spt != SPT_AUTO && {1'b0, spt} < tpb) ? {1'b0, spt} : mid;

  assign lane_restart[0] = cfg_restart;
  assign lane_restart[1] = cfg_restart | rx_realign;
  assign lane_target[0]  = tpb - PH_W'(1);
  assign lane_target[1]  = sample_idx;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    uart_bt_lane #(.DIV_W(DIV_W), .PH_W(PH_W)) u_lane (
      .clk_i, .rst_ni,
      .restart_i(lane_restart[g]),
      .div_eff_i(div_eff),
      .tpb_i(tpb),
      .target_i(lane_target[g]),
      .strobe_o(lane_strobe[g]),
      .phase_o(lane_phase[g])
    );
  end

  uart_bt_rxalign #(.FRAME_BITS(FRAME_BITS), .SYNC_STAGES(SYNC_STAGES)) u_rxalign (
    .clk_i, .rst_ni, .rx_i,
    .cfg_restart_i(cfg_restart),
    .sample_i(lane_strobe[1]),
    .realign_o(rx_realign)
  );

  assign tx_tick_o   = lane_strobe[0];
  assign rx_sample_o = lane_strobe[1];
  assign tx_phase    = lane_phase[0];
  assign rx_phase    = lane_phase[1];
endmodule

// File: rtl/uart_bit_timer_chk.sv
module uart_bit_timer_chk #(
  parameter int DIV_W = 16,
  parameter int PH_W  = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tx_tick_i,
  input logic             rx_sample_i,
  input logic             cfg_restart_i,
  input logic             rx_realign_i,
  input logic [PH_W-1:0]  tx_phase_i,
  input logic [PH_W-1:0]  rx_phase_i,
  input logic [PH_W-1:0]  tpb_i,
  input logic [DIV_W-1:0] div_eff_i,
  input logic [PH_W-1:0]  sample_idx_i
);
  logic [DIV_W+PH_W-1:0] bit_len;
  assign bit_len = {{PH_W{1'b0}}, div_eff_i} * {{DIV_W{1'b0}}, tpb_i};

  assert_single_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_tick_i && bit_len > 1) |=> !tx_tick_i);

  assert_single_sample_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_sample_i && bit_len > 1) |=> !rx_sample_i);

  assert_phase_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_phase_i < tpb_i) && (rx_phase_i < tpb_i));

  assert_sample_in_bit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_idx_i < tpb_i);

  assert_cfg_restart_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_restart_i |=> (!tx_tick_i && !rx_sample_i && tx_phase_i == '0 && rx_phase_i == '0));

  assert_realign_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_realign_i |=> (rx_phase_i == '0 && !rx_sample_i));
endmodule

bind uart_bit_timer uart_bit_timer_chk #(.DIV_W(uart_bt_pkg::DIV_W), .PH_W(uart_bt_pkg::PH_W)) u_chk (
  .clk_i(clk_i),
  .rst_ni(rst_ni),
  .tx_tick_i(tx_tick_o),
  .rx_sample_i(rx_sample_o),
  .cfg_restart_i(cfg_restart),
  .rx_realign_i(rx_realign),
  .tx_phase_i(tx_phase),
  .rx_phase_i(rx_phase),
  .tpb_i(tpb),
  .div_eff_i(div_eff),
  .sample_idx_i(sample_idx)
);

// File: tb/uart_bit_timer_bench.sv
module uart_bit_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       rx = 1'b1;
  logic       tx_tick, rx_sample;

  int checks = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  uart_bit_timer u_uart_bit_timer (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rx_i(rx), .tx_tick_o(tx_tick), .rx_sample_o(rx_sample)
  );

  task automatic summary();
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      checks++; bad++;
      $display("FAIL watchdog: act=%0d exp<=150000 cycles", cyc);
      summary();
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic bit pick(int sel);
    return (sel == 0) ? tx_tick : rx_sample;
  endfunction

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_div(int d);
    wr(4'd3, 8'h83);
    wr(4'd0, d[7:0]);
    wr(4'd1, d[15:8]);
    wr(4'd3, 8'h03);
  endtask

  // edges until the strobe is seen; pulses within the first skip edges are ignored
  task automatic meas(int sel, int skip, output int n);
    bit hit = 0;
    n = 0;
    while (!hit && n < 4000) begin
      @(posedge clk);
      @(negedge clk);
      n++;
      if (n > skip && pick(sel)) hit = 1;
    end
  endtask

  task automatic period_chk(int sel, int exp, string tag);
    int n;
    bit hit = 0;
    meas(sel, 0, n);
    n = 0;
    while (!hit && n < 4000) begin
      @(posedge clk);
      @(negedge clk);
      n++;
      if (n == 1 && exp > 1) chk("R11 strobe width", int'(pick(sel)), 0);
      if (pick(sel)) hit = 1;
    end
    chk(tag, n, exp);
  endtask

  task automatic rx_fall_chk(int exp, string tag);
    int n;
    @(negedge clk);
    rx = 1'b1;
    repeat (4) @(negedge clk);
    rx = 1'b0;
    meas(1, 2, n);
    chk(tag, n, exp);
  endtask

  task automatic t_reset();
    int n;
    repeat (3) @(negedge clk);
    chk("R1 tx low in reset", int'(tx_tick), 0);
    chk("R1 rx low in reset", int'(rx_sample), 0);
    rst_n = 1'b1;
    meas(0, 0, n);
    chk("R1 first tx after reset", n, 16);
  endtask

  task automatic t_mode16();
    period_chk(0, 16, "R2 default period");
    set_div(3);
    period_chk(0, 48, "R2 mode0 div3");
    wr(4'd9, 8'd1);
    period_chk(0, 48, "R2 mode1 div3");
  endtask

  task automatic t_mode4();
    wr(4'd9, 8'd2);
    period_chk(0, 12, "R3 mode2 div3");
  endtask

  task automatic t_prog();
    wr(4'd10, 8'd9);
    wr(4'd9, 8'd3);
    period_chk(0, 30, "R4 mode3 sc9 div3");
    wr(4'd10, 8'd0);
    set_div(2);
    period_chk(0, 2, "R4 mode3 sc0 div2");
  endtask

  task automatic t_div_zero();
    wr(4'd9, 8'd2);
    set_div(0);
    period_chk(0, 4, "R5 div0 as 1");
  endtask

  task automatic t_latch_gate();
    wr(4'd0, 8'd5);
    wr(4'd1, 8'd7);
    period_chk(0, 4, "R6 divisor gated");
  endtask

  task automatic t_restart();
    int n;
    wr(4'd9, 8'd0);
    meas(0, 0, n);
    chk("R10 tx after speed write", n, 16);
    wr(4'd9, 8'd2);
    meas(1, 0, n);
    chk("R10 rx after speed write", n, 2);
  endtask

  task automatic t_sample_point();
    wr(4'd9, 8'd3);
    wr(4'd10, 8'd9);
    set_div(3);
    wr(4'd11, 8'd2);
    rx_fall_chk(12, "R7 first sample at tick 2");
    period_chk(1, 30, "R7 sample period");
  endtask

  task automatic t_mid_default();
    wr(4'd11, 8'hFF);
    wr(4'd10, 8'd8);
    wr(4'd10, 8'd9);
    rx_fall_chk(18, "R8 auto point mode3");
    wr(4'd11, 8'd12);
    wr(4'd10, 8'd8);
    wr(4'd10, 8'd9);
    rx_fall_chk(18, "R8 point beyond bit");
    wr(4'd11, 8'hFF);
    wr(4'd9, 8'd2);
    rx_fall_chk(9, "R8 auto point mode2");
  endtask

  task automatic t_frame_guard();
    int first = 0;
    int cnt = 0;
    wr(4'd9, 8'd0);
    set_div(1);
    rx_fall_chk(11, "R9 start edge realign");
    for (int i = 1; i <= 20; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (rx_sample) begin
        cnt++;
        if (first == 0) first = i;
      end
      if (i == 4) rx = 1'b1;
      if (i == 8) rx = 1'b0;
    end
    chk("R9 mid-frame edge ignored", first, 16);
    chk("R9 single sample in window", cnt, 1);
    repeat (200) @(negedge clk);
    rx_fall_chk(11, "R9 realign after frame");
  endtask

  initial begin
    t_reset();
    t_mode16();
    t_mode4();
    t_prog();
    t_div_zero();
    t_latch_gate();
    t_restart();
    t_sample_point();
    t_mid_default();
    t_frame_guard();
    done = 1;
    summary();
  end
endmodule